// File: doc/BRIEF.md
# GPIO output routing and drive control

This block controls a bank of general-purpose pins from a small register bus. Each pin carries a 5-bit source select. The select decides whether the pin carries a bit written by software or one of five status signals made elsewhere on the chip. The five signals are an attention LED, a power LED, a network LED, an external receive-clear indication and a transmit-frame indication. A 2-bit drive mode per pin turns the level into an output enable. The modes are never drive, drive only when low, drive only when high, or drive at all times. The pins' input levels pass through a two-flop synchronizer and can be read back.

The register bus is single-cycle. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr` and shows the register contents as they stand in that cycle. A build-time switch reproduces a legacy read-back layout of the first select register, in which two adjacent fields overlap. Writes are not affected by this switch.

Top module: `gpio_route_ctrl`

## Requirements
- R1: Pin p has its 5-bit select field in the select register at address p/6 (integer division), at bits [(p mod 6)×5 +: 5]. Bits 30 and 31 of each select register are unused.
- R2: Select code 0 puts bit p of the software level register (address 5, bit p) on `pad_out[p]`. `pad_out` carries the routed level whatever the drive mode is.
- R3: Select codes 1 to 6 route, in order, the attention LED, the power LED, the network LED, the power LED again, the external receive-clear signal and the transmit-frame signal.
- R4: Any select code from 7 to 31 puts level 0 on the pin.
- R5: The drive mode of pin p is the 2-bit field at bits [(p mod 16)×2 +: 2] of address 3 for pins 0–15, or of address 4 for pins 16–17. The encodings are:
  - mode 0: `pad_oe` low.
  - mode 1: `pad_oe` high only while the routed level is 0.
  - mode 2: `pad_oe` high only while the routed level is 1.
  - mode 3: `pad_oe` always high.
- R6: Address 6 reads the pin inputs through two flops. A level present at a rising edge becomes readable after the second rising edge, and not after the first.
- R7: With `LEGACY_READBACK` set, a read of address 0 has a different layout. Bits [3:0] hold field 0 bits [3:0]. Bits [8:4] hold field 1. Bit 9 reads 0. Bits [31:10] are as in the normal read. Pin behaviour is identical to the normal build.
- R8: Reset, asynchronous and active low, clears every register and the synchronizer. Every pin then selects code 0 with mode 0, so `pad_oe` and `pad_out` are 0 and every address reads 0.
- R9: Unimplemented bits read as 0, and addresses 7 to 15 read 0. Writes to address 6 or to addresses 7 to 15 change no register and no pin.
- R10: A write changes registers and pins from the edge on which `reg_wr` is sampled high. A read of the same address in the write cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| src_attn_led | input | 1 | Attention LED status source |
| src_pwr_led | input | 1 | Power LED status source |
| src_net_led | input | 1 | Network LED status source |
| src_rx_clear | input | 1 | External receive-clear source |
| src_tx_frame | input | 1 | Transmit-frame source |
| pad_in | input | NUM_PINS (18) | Pin input levels, asynchronous |
| pad_out | output | NUM_PINS (18) | Routed level for each pin |
| pad_oe | output | NUM_PINS (18) | Output enable for each pin |

## Verification
A register write and a read of the same register can fall in the same cycle. A write of the software level register can also coincide with the pin output that depends on it. The bench provokes this by raising the write strobe with the address set to the level register and a new value on the bus. It then samples the read data and `pad_out` before the edge, expecting the old value in both. After the edge it expects the new value in both. A second collision comes from input changes landing while the synchronizer holds the previous level. The read-back is judged one edge and two edges after the change.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

  localparam int SEL_W        = 5;
  localparam int PINS_PER_MUX = 6;
  localparam int MODE_W       = 2;
  localparam int PINS_PER_DRV = 16;

  localparam int SEL_SW      = 0;
  localparam int SEL_ATTN    = 1;
  localparam int SEL_PWR     = 2;
  localparam int SEL_NET     = 3;
  localparam int SEL_PWR_ALT = 4;
  localparam int SEL_RXCLR   = 5;
  localparam int SEL_TXFRM   = 6;
  localparam int SEL_TOP     = SEL_TXFRM;

  typedef logic [SEL_W-1:0] sel_t;

  typedef enum logic [MODE_W-1:0] {
    DRV_OFF       = 2'd0,
    DRV_LOW_ONLY  = 2'd1,
    DRV_HIGH_ONLY = 2'd2,
    DRV_ALWAYS    = 2'd3
  } drv_mode_e;

  typedef struct packed {
    logic attn_led;
    logic pwr_led;
    logic net_led;
    logic rx_clear;
    logic tx_frame;
  } int_src_t;

  // Bit position of a pin's select field inside its select register.
  function automatic int sel_lsb(int pin);
    return (pin % PINS_PER_MUX) * SEL_W;
  endfunction

  // Bit position of a pin's drive-mode field inside its drive register.
  function automatic int mode_lsb(int pin);
    return (pin % PINS_PER_DRV) * MODE_W;
  endfunction

  function automatic logic route_level(sel_t sel, logic sw_bit, int_src_t src);
    logic r;
    case (int'(sel))
      SEL_SW:      r = sw_bit;
      SEL_ATTN:    r = src.attn_led;
      SEL_PWR:     r = src.pwr_led;
      SEL_NET:     r = src.net_led;
      SEL_PWR_ALT: r = src.pwr_led;
      SEL_RXCLR:   r = src.rx_clear;
      SEL_TXFRM:   r = src.tx_frame;
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic drive_enable(drv_mode_e m, logic level);
    logic r;
    case (m)
      DRV_OFF:       r = 1'b0;
      DRV_LOW_ONLY:  r = ~level;
      DRV_HIGH_ONLY: r = level;
      default:       r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [1:0]       warm_q;   // cycles since reset, saturating, for the check below

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign sync_o = sync_q;

  // R6: the read-back equals the raw input two edges earlier
  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_q == $past(raw_i, 2)));

endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route import gpio_route_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_t              sel_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sw_bit_i,
  input  int_src_t          src_i,
  output logic              level_o,
  output logic              oe_o
);

  assign level_o = route_level(sel_i, sw_bit_i, src_i);
  assign oe_o    = drive_enable(drv_mode_e'(mode_i), level_o);

  // R4: out-of-range codes never produce a high level
  a_r4_bad_code_low: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_i) > SEL_TOP) |-> !level_o);

  // R5: mode 0 never enables the driver
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DRV_OFF) |-> !oe_o);

  // R5: low-only mode enables only on a low level
  a_r5_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && mode_i == DRV_LOW_ONLY) |-> !level_o);

  // R5: high-only mode enables only on a high level
  a_r5_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && mode_i == DRV_HIGH_ONLY) |-> level_o);

  // R5: always mode keeps the driver on
  a_r5_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DRV_ALWAYS) |-> oe_o);

endmodule

// File: rtl/gpio_route_regs.sv
module gpio_route_regs import gpio_route_pkg::*; #(
  parameter int NUM_PINS        = 18,
  parameter int ADDR_W          = 4,
  parameter int DATA_W          = 32,
  parameter bit LEGACY_READBACK = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [NUM_PINS-1:0]              pin_sync,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_PINS-1:0][SEL_W-1:0]   sel_o,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  mode_o,
  output logic [NUM_PINS-1:0]              dout_o
);

  localparam int NUM_MUX   = (NUM_PINS + PINS_PER_MUX - 1) / PINS_PER_MUX;
  localparam int NUM_DRV   = (NUM_PINS + PINS_PER_DRV - 1) / PINS_PER_DRV;
  localparam int DRV_BASE  = NUM_MUX;
  localparam int DOUT_ADDR = DRV_BASE + NUM_DRV;
  localparam int PIN_ADDR  = DOUT_ADDR + 1;

  logic [NUM_PINS-1:0][SEL_W-1:0]  sel_q;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_q;
  logic [NUM_PINS-1:0]             dout_q;

  logic [31:0]        addr_x;
  logic [NUM_MUX-1:0] hit_mux;
  logic [NUM_DRV-1:0] hit_drv;
  logic               hit_dout;
  logic               hit_ignored;   // write that lands on no writable register

  assign addr_x = 32'(addr);

  always_comb begin
    for (int m = 0; m < NUM_MUX; m++) hit_mux[m] = wr_en && (addr_x == 32'(m));
    for (int d = 0; d < NUM_DRV; d++) hit_drv[d] = wr_en && (addr_x == 32'(DRV_BASE + d));
    hit_dout    = wr_en && (addr_x == 32'(DOUT_ADDR));
    hit_ignored = wr_en && !(|hit_mux) && !(|hit_drv) && !hit_dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= '0;
      dout_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (hit_mux[p / PINS_PER_MUX]) sel_q[p]  <= wdata[sel_lsb(p) +: SEL_W];
        if (hit_drv[p / PINS_PER_DRV]) mode_q[p] <= wdata[mode_lsb(p) +: MODE_W];
        if (hit_dout)                  dout_q[p] <= wdata[p];
      end
    end
  end

  assign sel_o  = sel_q;
  assign mode_o = mode_q;
  assign dout_o = dout_q;

  // Packed read views of the per-pin fields
  logic [NUM_MUX-1:0][DATA_W-1:0] mux_word;
  logic [NUM_DRV-1:0][DATA_W-1:0] drv_word;
  logic [DATA_W-1:0]              mux0_view;

  always_comb begin
    mux_word = '0;
    drv_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      mux_word[p / PINS_PER_MUX][sel_lsb(p) +: SEL_W]   = sel_q[p];
      drv_word[p / PINS_PER_DRV][mode_lsb(p) +: MODE_W] = mode_q[p];
    end
  end

  generate
    if (LEGACY_READBACK) begin : g_legacy_view
      // field 1 lands one place low; it overwrites field 0's top bit, bit 9 reads 0
      assign mux0_view = {mux_word[0][DATA_W-1:10], 1'b0, mux_word[0][9:5], mux_word[0][3:0]};
    end else begin : g_plain_view
      assign mux0_view = mux_word[0];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int m = 0; m < NUM_MUX; m++)
      if (addr_x == 32'(m)) rdata = (m == 0) ? mux0_view : mux_word[m];
    for (int d = 0; d < NUM_DRV; d++)
      if (addr_x == 32'(DRV_BASE + d)) rdata = drv_word[d];
    if (addr_x == 32'(DOUT_ADDR)) rdata = DATA_W'(dout_q);
    if (addr_x == 32'(PIN_ADDR))  rdata = DATA_W'(pin_sync);
  end

  // R1: a write to select register 0 lands in pin 0's field
  a_r1_field0_load: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mux[0] |=> (sel_q[0] == $past(wdata[SEL_W-1:0])));

  // R9: writes to read-only or unmapped addresses change nothing
  a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ignored |=> ($stable(sel_q) && $stable(mode_q) && $stable(dout_q)));

  // R10: without a write strobe the registers hold
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sel_q) && $stable(mode_q) && $stable(dout_q)));

endmodule

// File: rtl/gpio_route_ctrl.sv
module gpio_route_ctrl import gpio_route_pkg::*; #(
  parameter int NUM_PINS        = 18,
  parameter int ADDR_W          = 4,
  parameter int DATA_W          = 32,
  parameter bit LEGACY_READBACK = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                src_attn_led,
  input  logic                src_pwr_led,
  input  logic                src_net_led,
  input  logic                src_rx_clear,
  input  logic                src_tx_frame,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  logic [NUM_PINS-1:0][SEL_W-1:0]  sel_vec;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_vec;
  logic [NUM_PINS-1:0]             dout_vec;
  logic [NUM_PINS-1:0]             pad_sync;
  int_src_t                        isrc;

  assign isrc = '{attn_led: src_attn_led, pwr_led: src_pwr_led, net_led: src_net_led,
                  rx_clear: src_rx_clear, tx_frame: src_tx_frame};

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (pad_sync)
  );

  gpio_route_regs #(
    .NUM_PINS        (NUM_PINS),
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .LEGACY_READBACK (LEGACY_READBACK)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pin_sync (pad_sync),
    .rdata    (reg_rdata),
    .sel_o    (sel_vec),
    .mode_o   (mode_vec),
    .dout_o   (dout_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_route u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel_vec[p]),
      .mode_i   (mode_vec[p]),
      .sw_bit_i (dout_vec[p]),
      .src_i    (isrc),
      .level_o  (pad_out[p]),
      .oe_o     (pad_oe[p])
    );
  end

  // R2: pin 0 on code 0 in always mode drives the software bit
  a_r2_sw_route: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vec[0] == '0 && mode_vec[0] == DRV_ALWAYS) |-> (pad_oe[0] && pad_out[0] == dout_vec[0]));

endmodule

// File: tb/gpio_route_ctrl_test.sv
module gpio_route_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NP = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        s_attn = 0, s_pwr = 0, s_net = 0, s_rx = 0, s_tx = 0;
  logic [NP-1:0] pin_in = '0;
  logic [31:0]   rdata_p, rdata_l;
  logic [NP-1:0] out_p, oe_p, out_l, oe_l;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_route_ctrl #(.LEGACY_READBACK(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_p), .src_attn_led(s_attn), .src_pwr_led(s_pwr), .src_net_led(s_net),
    .src_rx_clear(s_rx), .src_tx_frame(s_tx), .pad_in(pin_in), .pad_out(out_p), .pad_oe(oe_p));

  gpio_route_ctrl #(.LEGACY_READBACK(1'b1)) uut_leg (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_l), .src_attn_led(s_attn), .src_pwr_led(s_pwr), .src_net_led(s_net),
    .src_rx_clear(s_rx), .src_tx_frame(s_tx), .pad_in(pin_in), .pad_out(out_l), .pad_oe(oe_l));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] vp, output logic [31:0] vl);
    addr = 4'(a);
    #1;
    vp = rdata_p;
    vl = rdata_l;
  endtask

  task automatic set_src(input logic [4:0] s);
    {s_attn, s_pwr, s_net, s_rx, s_tx} = s;
  endtask

  // expected routed level, from the code table of R2/R3/R4
  function automatic logic exp_lvl(input int code, input logic sw, input logic [4:0] s);
    case (code)
      0: return sw;
      1: return s[4];
      2: return s[3];
      3: return s[2];
      4: return s[3];
      5: return s[1];
      6: return s[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] rep6(input int c);
    logic [31:0] r = '0;
    for (int i = 0; i < 6; i++) r = r | (32'(c & 31) << (5 * i));
    return r;
  endfunction

  function automatic logic [31:0] rep16(input int m);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) r = r | (32'(m & 3) << (2 * i));
    return r;
  endfunction

  task automatic all_sel(input int c);
    for (int m = 0; m < 3; m++) wr(m, rep6(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] vp, vl, e, w, old_v, new_v;
    logic [NP-1:0] ev, eo, dpat, pat_a;
    int codes [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 19, 31};

    // R8: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(a, vp, vl);
      chk("R8 reset read", vp, 32'h0);
    end
    chk("R8 reset oe", 32'(oe_p), 32'h0);
    chk("R8 reset out", 32'(out_p), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3/R4: code sweep over every source pattern, all pins driven
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    for (int ci = 0; ci < 10; ci++) begin
      all_sel(codes[ci]);
      for (int s = 0; s < 32; s++) begin
        dpat = NP'(32'(s) * 32'h9E37 + 32'h1234B);
        wr(5, 32'(dpat));
        set_src(5'(s));
        #1;
        for (int p = 0; p < NP; p++) ev[p] = exp_lvl(codes[ci], dpat[p], 5'(s));
        if (codes[ci] == 0)     chk("R2 software route", 32'(out_p), 32'(ev));
        else if (codes[ci] < 7) chk("R3 source route", 32'(out_p), 32'(ev));
        else                    chk("R4 invalid code low", 32'(out_p), 32'(ev));
      end
      chk("R5 always mode oe", 32'(oe_p), 32'h3FFFF);
    end

    // R5: every mode with mixed levels
    all_sel(0);
    wr(5, 32'h2AAAA);
    for (int m = 0; m < 4; m++) begin
      wr(3, rep16(m));
      wr(4, rep16(m));
      #1;
      case (m)
        0: eo = '0;
        1: eo = ~NP'(32'h2AAAA);
        2: eo = NP'(32'h2AAAA);
        default: eo = '1;
      endcase
      chk("R5 drive mode", 32'(oe_p), 32'(eo));
      chk("R2 level independent of mode", 32'(out_p), 32'h2AAAA);
    end

    // R5: drive field position per pin
    wr(5, 32'h3FFFF);
    for (int p = 0; p < NP; p++) begin
      wr(3, (p < 16) ? (32'd3 << (2 * p)) : 32'h0);
      wr(4, (p >= 16) ? (32'd3 << (2 * (p - 16))) : 32'h0);
      #1;
      chk("R5 drive field position", 32'(oe_p), 32'h1 << p);
    end

    // R1: select field position per pin, transmit-frame source only
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    wr(5, 32'h0);
    set_src(5'b00001);
    for (int p = 0; p < NP; p++) begin
      w = 32'd6 << (5 * (p % 6));
      for (int m = 0; m < 3; m++) wr(m, (m == p / 6) ? w : 32'h0);
      #1;
      chk("R1 field position out", 32'(out_p), 32'h1 << p);
      chk("R1 field position legacy out", 32'(out_l), 32'h1 << p);
      rd(p / 6, vp, vl);
      chk("R1 select readback", vp, w);
    end

    // R7: legacy read-back layout of select register 0
    set_src(5'b11111);
    wr(5, 32'h15555);
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: w = 32'h3FFF_FFFF;
        1: w = 32'h0000_03E0;
        2: w = 32'h0000_001F;
        default: w = 32'h1234_5678 & 32'h3FFF_FFFF;
      endcase
      wr(0, w);
      rd(0, vp, vl);
      e = (w & 32'h3FFF_FC00) | (((w >> 5) & 32'h1F) << 4) | (w & 32'hF);
      chk("R7 legacy readback", vl, e);
      chk("R7 plain readback", vp, w);
      chk("R7 legacy pins unaffected", 32'(out_l), 32'(out_p));
    end

    // R9: unimplemented bits and unmapped addresses
    wr(2, 32'hFFFF_FFFF);
    rd(2, vp, vl);
    chk("R9 select unused bits", vp, 32'h3FFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    rd(4, vp, vl);
    chk("R9 drive-high unused bits", vp, 32'h0000_000F);
    wr(5, 32'hFFFF_FFFF);
    rd(5, vp, vl);
    chk("R9 level register unused bits", vp, 32'h0003_FFFF);
    for (int a = 7; a < 16; a++) begin
      rd(a, vp, vl);
      chk("R9 unmapped read", vp, 32'h0);
    end

    // R9: ignored writes
    all_sel(0);
    wr(5, 32'h0F0F0);
    pat_a = NP'(32'h15A5A);
    pin_in = pat_a;
    repeat (3) @(negedge clk);
    wr(6, 32'hFFFF_FFFF);
    wr(11, 32'hFFFF_FFFF);
    wr(15, 32'h0);
    rd(5, vp, vl);
    chk("R9 level reg after ignored write", vp, 32'h0F0F0);
    chk("R9 pins after ignored write", 32'(out_p), 32'h0F0F0);
    rd(6, vp, vl);
    chk("R9 input read after ignored write", vp, 32'(pat_a));
    rd(0, vp, vl);
    chk("R9 select reg after ignored write", vp, 32'h0);

    // R6: two-edge synchronizer
    for (int i = 0; i < 2; i++) begin
      dpat = (i == 0) ? NP'(32'h3A5C1) : NP'(32'h05A3E);
      old_v = 32'(pin_in);
      @(negedge clk);
      pin_in = dpat;
      addr = 4'd6;
      @(negedge clk);
      #1;
      chk("R6 one edge later", rdata_p, old_v);
      @(negedge clk);
      #1;
      chk("R6 two edges later", rdata_p, 32'(dpat));
    end

    // R10: write and read of the level register in the same cycle
    old_v = 32'h0F0F0;
    new_v = 32'h30C3C;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd5; wdata = new_v;
    #1;
    chk("R10 read in write cycle", rdata_p, old_v);
    chk("R10 pins in write cycle", 32'(out_p), old_v);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R10 read after write edge", rdata_p, new_v);
    chk("R10 pins after write edge", 32'(out_p), new_v);

    // R8: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(5, vp, vl);
    chk("R8 mid reset level reg", vp, 32'h0);
    rd(6, vp, vl);
    chk("R8 mid reset synchronizer", vp, 32'h0);
    rd(3, vp, vl);
    chk("R8 mid reset drive reg", vp, 32'h0);
    chk("R8 mid reset oe", 32'(oe_p), 32'h0);
    chk("R8 mid reset out", 32'(out_p), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule